// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block recovers characters from an asynchronous serial line. The line is first retimed through two flip-flops. A 16x oversampling enable, generated outside the block, then paces every bit decision. A falling edge seen on an enable tick arms a start-bit check. The check re-reads the line half a bit later and abandons the frame if the line has gone back high. Every later data, parity and stop bit is sampled once, at its own centre, sixteen ticks after the previous sample.

Three line-control inputs configure the frame: a word length of 5 to 8 bits, a parity enable, and a two-bit parity kind (odd, even, forced one or forced zero). For each finished frame the block raises a one-cycle strobe together with the data byte and three tags: parity error, framing error and break. When a stop bit is sampled low, the receiver treats that low level as the start of the next character and carries straight on. When the line has stayed low over a whole frame, the block reports a break and then ignores the line until it returns high.

The block sits between a baud-rate tick generator and whatever stores the characters. That might be a FIFO or a status register set in the surrounding design.

Top module: `uart_rx_brk`

## Requirements
- R1: The line passes through a two-flop synchroniser that resets to 1. A start bit is accepted only if the line still reads 0 eight ticks after the falling edge was seen, so a low pulse shorter than half a bit produces no character.
- R2: Data bits arrive least significant bit first. `cfg_wlen` encodes the word length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits above the word length read as 0 in `chr_data`.
- R3: With `cfg_par_en`=1, one parity bit follows the data. `cfg_par_kind` selects the expected parity value: 00 = odd (data plus parity has an odd number of ones), 01 = even, 10 = always 1, 11 = always 0. `chr_perr` is 1 when the received parity bit differs from the expected value. With `cfg_par_en`=0, no parity bit is read and `chr_perr` is 0.
- R4: `chr_ferr` is 1 when the sampled stop bit is 0, and 0 otherwise.
- R5: After a stop bit sampled 0 that is not a break, the receiver takes that low bit as the start bit of the next character. It samples the next data bit sixteen ticks later, with no wait for an idle line.
- R6: When start, data, parity (if enabled) and stop are all sampled 0, the character is reported with `chr_brk`=1, `chr_ferr`=1, `chr_perr`=0 and `chr_data`=0x00.
- R7: After a break, no further character is produced while the line stays 0. Once the line returns to 1, start detection works again as usual.
- R8: `chr_valid` is high for exactly one clock per character. `chr_data` and the tags hold their values until the next strobe.
- R9: After reset, `chr_valid`, `chr_data`, `chr_perr`, `chr_ferr` and `chr_brk` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Word length code (0..3 for 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_kind | input | 2 | Parity kind: odd, even, forced 1, forced 0 |
| chr_valid | output | 1 | One-cycle strobe for a finished character |
| chr_data | output | 8 | Received data, zero-filled above the word length |
| chr_perr | output | 1 | Parity error tag |
| chr_ferr | output | 1 | Framing error tag |
| chr_brk | output | 1 | Break tag |

## Verification
A wrong tick count or bit index inside the frame sequencer shows up at the ports within one character time. The strobe then comes at the wrong point in the frame, or the data and tags come out shifted or wrong. A sequencer that fails to leave the post-break wait state shows as total silence on the next well-formed frame. One that leaves the wait state too early gives extra break characters while the line stays low. A resynchronisation fault after a bad stop bit changes the character that follows, so the bench sends a well-formed frame straight after each framing error and checks both characters.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OVS_DEFAULT = 16;
    localparam int DATA_W      = 8;
    localparam int IDX_W       = $clog2(DATA_W);
    localparam int MIN_WORD    = 5;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_HOLD
    } rx_state_e;

    // Raw samples of one frame, handed from the sequencer to the tagger
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              has_par;
        logic              par_bit;
        logic              stop_bit;
        logic              all_low;
    } raw_frame_t;

    // Tagged character presented at the block edge
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

    function automatic logic expected_parity(input logic [DATA_W-1:0] d,
                                             input logic [1:0] kind);
        logic r;
        case (par_kind_e'(kind))
            PAR_ODD:   r = ~(^d);
            PAR_EVEN:  r = ^d;
            PAR_MARK:  r = 1'b1;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] last_index(input logic [1:0] wlen);
        return IDX_W'(MIN_WORD - 1) + {1'b0, wlen};
    endfunction

endpackage

// File: rtl/rx_sync2.sv
module rx_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RESET_VAL;
            sync_q <= RESET_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

    // R1: the retimed line reflects the raw input exactly two clocks later
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_sync_two_stage_R1: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd3) |-> (sync_q == $past(din, 2)));

endmodule

// File: rtl/rx_frame_seq.sv
module rx_frame_seq
    import uart_rx_pkg::*;
#(
    parameter int OVS = OVS_DEFAULT
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rx,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    output logic       done,
    output raw_frame_t raw
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);

    rx_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DATA_W-1:0]  dbuf_q;
    logic               par_q;
    logic               all_low_q;
    logic [IDX_W-1:0]   last_idx;
    logic               bit_mid;

    assign last_idx = last_index(cfg_wlen);
    assign bit_mid  = tick && (cnt_q == FULL_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            dbuf_q    <= '0;
            par_q     <= 1'b0;
            all_low_q <= 1'b0;
            done      <= 1'b0;
            raw       <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (tick && !rx) begin
                        state_q <= S_START;
                        cnt_q   <= '0;
                    end
                end
                S_START: begin
                    if (tick) begin
                        if (cnt_q == HALF_LAST) begin
                            cnt_q <= '0;
                            if (rx) begin
                                state_q <= S_IDLE;
                            end else begin
                                state_q   <= S_DATA;
                                idx_q     <= '0;
                                dbuf_q    <= '0;
                                par_q     <= 1'b0;
                                all_low_q <= 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                S_DATA: begin
                    if (bit_mid) begin
                        cnt_q         <= '0;
                        dbuf_q[idx_q] <= rx;
                        all_low_q     <= all_low_q & ~rx;
                        if (idx_q == last_idx) begin
                            state_q <= cfg_par_en ? S_PAR : S_STOP;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_PAR: begin
                    if (bit_mid) begin
                        cnt_q     <= '0;
                        par_q     <= rx;
                        all_low_q <= all_low_q & ~rx;
                        state_q   <= S_STOP;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_STOP: begin
                    if (bit_mid) begin
                        cnt_q <= '0;
                        done  <= 1'b1;
                        raw   <= '{data:     dbuf_q,
                                   has_par:  cfg_par_en,
                                   par_bit:  par_q,
                                   stop_bit: rx,
                                   all_low:  all_low_q & ~rx};
                        if (rx) begin
                            state_q <= S_IDLE;
                        end else if (all_low_q) begin
                            state_q <= S_HOLD;
                        end else begin
                            // low stop bit doubles as the next start bit
                            state_q   <= S_DATA;
                            idx_q     <= '0;
                            dbuf_q    <= '0;
                            par_q     <= 1'b0;
                            all_low_q <= 1'b1;
                        end
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_HOLD: begin
                    if (rx) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R1: a start bit that reads high at its centre is abandoned
    assert_false_start_abort_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_START && tick && cnt_q == HALF_LAST && rx) |=> (state_q == S_IDLE));

    // R5: a non-break framing error moves straight into the next data bit
    assert_resync_after_ferr_R5: assert property (@(posedge clk) disable iff (rst)
        (done && !raw.stop_bit && !raw.all_low) |-> (state_q == S_DATA && cnt_q == '0 && idx_q == '0));

    // R7: the post-break wait persists while the line stays low
    assert_hold_until_mark_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_HOLD && !rx) |=> (state_q == S_HOLD));

    // R8: a frame completes only on an oversampling tick
    assert_done_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(tick));

endmodule

// File: rtl/rx_char_tagger.sv
module rx_char_tagger
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       done,
    input  raw_frame_t raw,
    input  logic [1:0] cfg_par_kind,
    output logic       out_valid,
    output rx_char_t   out_char
);
    rx_char_t next_char;
    logic     is_break;

    always_comb begin
        is_break       = raw.all_low;
        next_char.brk  = is_break;
        next_char.ferr = ~raw.stop_bit;
        next_char.perr = ~is_break & raw.has_par &
                         (raw.par_bit != expected_parity(raw.data, cfg_par_kind));
        next_char.data = is_break ? '0 : raw.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= done;
            if (done) out_char <= next_char;
        end
    end

    // R8: strobe lasts a single cycle
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8: result holds between strobes
    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_char));

    // R6: break characters carry zero data, framing error and no parity error
    assert_break_tags_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_char.brk) |-> (out_char.ferr && !out_char.perr && out_char.data == '0));

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OVS = OVS_DEFAULT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick16,
    input  logic        rx_line,
    input  logic [1:0]  cfg_wlen,
    input  logic        cfg_par_en,
    input  logic [1:0]  cfg_par_kind,
    output logic        chr_valid,
    output logic [7:0]  chr_data,
    output logic        chr_perr,
    output logic        chr_ferr,
    output logic        chr_brk
);
    logic       rx_sync;
    logic       frame_done;
    raw_frame_t frame_raw;
    rx_char_t   char_q;

    rx_sync2 #(.RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (rx_sync)
    );

    rx_frame_seq #(.OVS(OVS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick16),
        .rx         (rx_sync),
        .cfg_wlen   (cfg_wlen),
        .cfg_par_en (cfg_par_en),
        .done       (frame_done),
        .raw        (frame_raw)
    );

    rx_char_tagger u_tag (
        .clk          (clk),
        .rst          (rst),
        .done         (frame_done),
        .raw          (frame_raw),
        .cfg_par_kind (cfg_par_kind),
        .out_valid    (chr_valid),
        .out_char     (char_q)
    );

    assign chr_data = char_q.data;
    assign chr_perr = char_q.perr;
    assign chr_ferr = char_q.ferr;
    assign chr_brk  = char_q.brk;

    // R2: bits above the configured word length read as zero
    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (rst)
        chr_valid |-> ((chr_data >> (4'd5 + {2'b00, cfg_wlen})) == 8'd0));

endmodule

// File: tb/uart_rx_brk_bench.sv
module uart_rx_brk_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int BIT_CLK    = 16 * TICK_DIV;
    localparam int WDOG_LIMIT = 150000;
    localparam int NVEC       = 8;

    // fields: [13:12] wlen, [11] par_en, [10:9] par_kind, [8] bad parity, [7:0] data
    localparam logic [13:0] VEC [0:NVEC-1] = '{
        {2'd3, 1'b0, 2'b00, 1'b0, 8'hA5},
        {2'd3, 1'b1, 2'b01, 1'b0, 8'h3C},
        {2'd3, 1'b1, 2'b00, 1'b1, 8'h81},
        {2'd0, 1'b0, 2'b00, 1'b0, 8'hFF},
        {2'd1, 1'b1, 2'b10, 1'b0, 8'hEA},
        {2'd2, 1'b1, 2'b11, 1'b1, 8'h55},
        {2'd3, 1'b1, 2'b00, 1'b0, 8'h00},
        {2'd2, 1'b1, 2'b01, 1'b1, 8'h7F}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_kind = 2'b00;
    logic       chr_valid;
    logic [7:0] chr_data;
    logic       chr_perr, chr_ferr, chr_brk;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    int got_n = 0;
    int dbl_strobe = 0;
    logic prev_valid = 1'b0;
    logic [7:0] got_data [0:63];
    logic [2:0] got_tags [0:63];   // {perr, ferr, brk}
    int tick_div_q = 0;

    uart_rx_brk u_uart_rx_brk (
        .clk          (clk),
        .rst          (rst),
        .tick16       (tick16),
        .rx_line      (rx_line),
        .cfg_wlen     (cfg_wlen),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_kind (cfg_par_kind),
        .chr_valid    (chr_valid),
        .chr_data     (chr_data),
        .chr_perr     (chr_perr),
        .chr_ferr     (chr_ferr),
        .chr_brk      (chr_brk)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        tick_div_q <= (tick_div_q == TICK_DIV - 1) ? 0 : tick_div_q + 1;
        tick16     <= (tick_div_q == TICK_DIV - 1);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (chr_valid) begin
                if (got_n < 64) begin
                    got_data[got_n] = chr_data;
                    got_tags[got_n] = {chr_perr, chr_ferr, chr_brk};
                end
                got_n = got_n + 1;
                if (prev_valid) dbl_strobe = dbl_strobe + 1;
            end
            prev_valid = chr_valid;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == WDOG_LIMIT) begin
            n_checks = n_checks + 1;
            n_errors = n_errors + 1;
            $display("FAIL R8 watchdog: actual=%0d cycles expected below %0d", cyc, WDOG_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks = n_checks + 1;
        if (act != exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic line_for(input logic v, input int nbits);
        rx_line = v;
        repeat (nbits * BIT_CLK) @(negedge clk);
    endtask

    function automatic logic model_parity(input logic [7:0] d, input logic [1:0] kind);
        case (kind)
            2'b00:   return ~(^d);
            2'b01:   return ^d;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] mask_word(input logic [7:0] d, input logic [1:0] wlen);
        return d & ((8'd1 << (5 + wlen)) - 8'd1);
    endfunction

    task automatic send_data_bits(input logic [7:0] d, input logic [1:0] wlen);
        for (int i = 0; i < 5 + int'(wlen); i++) line_for(d[i], 1);
    endtask

    task automatic send_frame(input logic [1:0] wlen, input logic pen, input logic [1:0] kind,
                              input logic bad, input logic [7:0] d, input logic stopv);
        logic [7:0] m;
        m = mask_word(d, wlen);
        line_for(1'b0, 1);
        send_data_bits(m, wlen);
        if (pen) line_for(model_parity(m, kind) ^ bad, 1);
        line_for(stopv, 1);
    endtask

    task automatic expect_char(input int idx, input string req, input logic [7:0] d,
                               input logic perr, input logic ferr, input logic brk);
        check_eq(req, $sformatf("char %0d data", idx), int'(got_data[idx]), int'(d));
        check_eq(req, $sformatf("char %0d tags {perr,ferr,brk}", idx),
                 int'(got_tags[idx]), int'({perr, ferr, brk}));
    endtask

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        check_eq("R9", "chr_valid after reset", int'(chr_valid), 0);
        check_eq("R9", "chr_data after reset", int'(chr_data), 0);
        check_eq("R9", "tags after reset", int'({chr_perr, chr_ferr, chr_brk}), 0);

        // R2 R3 R4: table of well-formed frames
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] w;
            logic       pe, bd;
            logic [1:0] pk;
            logic [7:0] dd;
            {w, pe, pk, bd, dd} = VEC[v];
            cfg_wlen = w; cfg_par_en = pe; cfg_par_kind = pk;
            base = got_n;
            send_frame(w, pe, pk, bd, dd, 1'b1);
            line_for(1'b1, 2);
            check_eq("R8", $sformatf("vector %0d char count", v), got_n - base, 1);
            expect_char(base, "R2_R3_R4", mask_word(dd, w), pe & bd, 1'b0, 1'b0);
            check_eq("R8", $sformatf("vector %0d data held", v), int'(chr_data), int'(mask_word(dd, w)));
        end

        // R1: short low glitch is not a start bit
        cfg_wlen = 2'd3; cfg_par_en = 1'b0;
        base = got_n;
        rx_line = 1'b0;
        repeat (5 * TICK_DIV) @(negedge clk);
        line_for(1'b1, 2);
        check_eq("R1", "glitch produced characters", got_n - base, 0);
        send_frame(2'd3, 1'b0, 2'b00, 1'b0, 8'h3E, 1'b1);
        line_for(1'b1, 2);
        check_eq("R1", "frame after glitch count", got_n - base, 1);
        expect_char(base, "R1", 8'h3E, 1'b0, 1'b0, 1'b0);

        // R4 R5: bad stop bit then next character with no start bit
        base = got_n;
        send_frame(2'd3, 1'b0, 2'b00, 1'b0, 8'h5A, 1'b0);
        send_data_bits(8'hC3, 2'd3);
        line_for(1'b1, 3);
        check_eq("R5", "resync char count", got_n - base, 2);
        expect_char(base, "R4", 8'h5A, 1'b0, 1'b1, 1'b0);
        expect_char(base + 1, "R5", 8'hC3, 1'b0, 1'b0, 1'b0);

        // R5 R6: zero data with a high parity bit is a framing error, not a break
        cfg_par_en = 1'b1; cfg_par_kind = 2'b00;
        base = got_n;
        send_frame(2'd3, 1'b1, 2'b00, 1'b0, 8'h00, 1'b0);
        line_for(1'b1, 12);
        check_eq("R6", "non-break zero frame count", got_n - base, 2);
        expect_char(base, "R6", 8'h00, 1'b0, 1'b1, 1'b0);
        expect_char(base + 1, "R5", 8'hFF, 1'b0, 1'b0, 1'b0);

        // R6 R7: break on 8 bits without parity
        cfg_par_en = 1'b0;
        base = got_n;
        line_for(1'b0, 15);
        check_eq("R6", "break char count", got_n - base, 1);
        expect_char(base, "R6", 8'h00, 1'b0, 1'b1, 1'b1);
        line_for(1'b0, 10);
        check_eq("R7", "chars while line held low", got_n - base, 1);
        line_for(1'b1, 2);
        send_frame(2'd3, 1'b0, 2'b00, 1'b0, 8'h96, 1'b1);
        line_for(1'b1, 2);
        check_eq("R7", "chars after line high", got_n - base, 2);
        expect_char(base + 1, "R7", 8'h96, 1'b0, 1'b0, 1'b0);

        // R6: break on 7 bits with odd parity suppresses the parity error
        cfg_wlen = 2'd2; cfg_par_en = 1'b1; cfg_par_kind = 2'b00;
        base = got_n;
        line_for(1'b0, 15);
        line_for(1'b1, 2);
        check_eq("R6", "parity break count", got_n - base, 1);
        expect_char(base, "R6", 8'h00, 1'b0, 1'b1, 1'b1);

        // R8: never two strobes back to back
        check_eq("R8", "back-to-back strobes", dbl_strobe, 0);

        summary();
        $finish;
    end

endmodule